// File: doc/BRIEF.md
# Dual-mode bridge gate generator

This block drives the eight switches of an isolated converter built from two full bridges, one on the high-voltage side and one on the low-voltage side, linked by a transformer. Every bridge switches its two diagonal pairs as complementary units, with a programmable dead time between them. A free-running carrier counter sets a fixed switching period. Within that period the block works in one of two modulation modes. In the in-phase PWM mode both bridges switch together, as a synchronous rectifier, with a programmable on-time. In the phase-shift mode both bridges run close to half-period pulses, and one bridge is displaced from the other by a bounded delay.

The mode is chosen from load. The block multiplies the output voltage word by the output current word. In forward flow (high side to low side) it uses the low-side sensor pair. In backward flow it uses the high-side pair. It compares that product against the threshold for the current direction, with a hysteresis band around it. Heavy load selects the phase-shift mode and light load selects PWM. In forward flow the high bridge leads. In backward flow the low bridge leads. Mode, direction, duty, shift, dead time and period are captured only when the carrier wraps, so settings never change inside a running period.

Top module: `dual_mode_gatedrv`

## Requirements
- R1: The gate pattern repeats every `period_len` clock cycles; a new `period_len` takes effect at the next carrier wrap.
- R2: Pair bits move as one: gate[0]=gate[3] (high pair A), gate[1]=gate[2] (high pair B), gate[4]=gate[7] (low pair A), gate[5]=gate[6] (low pair B); pair A and pair B of a bridge are never high together.
- R3: Pair A is on for local phase [dead, end) and pair B for [half+dead, half+end), where half = period/2 and dead = max(dead_len,1); in PWM mode with on-time end the gap from pair A falling to pair B rising is half+dead-end cycles.
- R4: In PWM mode (mode_psh=0) gate[0] and gate[4] rise in the same cycle, and the pair-A on-time is min(duty_len, half) - dead cycles.
- R5: In phase-shift mode (mode_psh=1) the pair-A on-time is half - dead cycles, and the delay between the bridges is min(shift_len, half/5) cycles.
- R6: The measured power is v_lo*i_lo when dir_bwd=0 and v_hi*i_hi when dir_bwd=1; the words of the other side have no effect on the mode.
- R7: From PWM the block enters phase-shift mode when power > threshold + hyst_band; from phase-shift it returns to PWM when power < threshold - hyst_band (floored at 0); otherwise the mode holds. The threshold is thr_fwd for dir_bwd=0 and thr_bwd for dir_bwd=1.
- R8: mode_psh changes only at a carrier wrap; in forward flow gate[0] rises exactly dead+1 cycles after mode_psh changes.
- R9: While rst is high all eight gates are low and mode_psh is 0.
- R10: With dir_bwd=0 in phase-shift mode gate[4] rises the shift delay after gate[0]; with dir_bwd=1 gate[4] rises the shift delay before gate[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_bwd | input | 1 | Power-flow direction: 0 forward, 1 backward |
| period_len | input | 12 | Switching period in clock cycles |
| duty_len | input | 12 | PWM-mode pair on-time end, in cycles |
| shift_len | input | 12 | Requested phase-shift delay in cycles |
| dead_len | input | 12 | Dead time in cycles |
| v_hi | input | 12 | High-side voltage sample |
| i_hi | input | 12 | High-side current sample |
| v_lo | input | 12 | Low-side voltage sample |
| i_lo | input | 12 | Low-side current sample |
| thr_fwd | input | 24 | Mode threshold for forward flow |
| thr_bwd | input | 24 | Mode threshold for backward flow |
| hyst_band | input | 24 | Hysteresis half-width around the threshold |
| gate | output | 8 | Switch drives, pairs as listed in R2 |
| mode_psh | output | 1 | Active mode: 0 PWM, 1 phase-shift |

## Verification
The stimulus walks the selected power from light through heavy load in both directions. It uses loads just inside and just outside the hysteresis band, so holding the mode can be told apart from switching it. The words of the unused sensor side are set to extreme values, which exposes a wrong choice of sensor pair. For each setting the bench measures the high-bridge on-time, the gap to the opposite pair, the repeat interval and the signed delay between the two bridges. These figures separate PWM from phase-shift, forward lead from backward lead, and clamped from unclamped duty and shift. Mode changes are timed against the next high-bridge edge to show they land on a period boundary.

// File: rtl/dmg_pkg.sv
package dmg_pkg;

    localparam int CNT_W = 12;
    localparam int V_W   = 12;
    localparam int I_W   = 12;
    localparam int P_W   = V_W + I_W;
    localparam int NUM_BRIDGES = 2;
    localparam int SHIFT_DIV   = 5;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [P_W-1:0]   pwr_t;

    typedef enum logic {
        MODE_PWM = 1'b0,
        MODE_PSH = 1'b1
    } mode_e;

    typedef struct packed {
        cnt_t  period;
        cnt_t  half;
        cnt_t  on_end;
        cnt_t  dead;
        cnt_t  shift;
        mode_e mode;
        logic  bwd;
    } frame_t;

    function automatic cnt_t cnt_min(input cnt_t a, input cnt_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic cnt_t wrap_sub(input cnt_t c, input cnt_t d, input cnt_t per);
        logic [CNT_W:0] tmp;
        tmp = {1'b0, c} + {1'b0, per} - {1'b0, d};
        return (c >= d) ? (c - d) : tmp[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/dmg_mode_sel.sv
module dmg_mode_sel
    import dmg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_bwd,
    input  logic [V_W-1:0]   v_hi,
    input  logic [I_W-1:0]   i_hi,
    input  logic [V_W-1:0]   v_lo,
    input  logic [I_W-1:0]   i_lo,
    input  pwr_t             thr_fwd,
    input  pwr_t             thr_bwd,
    input  pwr_t             hyst_band,
    output mode_e            mode_req
);

    pwr_t power_q;
    pwr_t thr_q;
    logic [P_W:0] upper;
    pwr_t lower;

    // sample the direction-appropriate sensor pair and threshold
    always_ff @(posedge clk) begin
        if (rst) begin
            power_q <= '0;
            thr_q   <= '0;
        end else begin
            power_q <= dir_bwd ? (pwr_t'(v_hi) * pwr_t'(i_hi))
                               : (pwr_t'(v_lo) * pwr_t'(i_lo));
            thr_q   <= dir_bwd ? thr_bwd : thr_fwd;
        end
    end

    always_comb begin
        upper = {1'b0, thr_q} + {1'b0, hyst_band};
        lower = (thr_q > hyst_band) ? (thr_q - hyst_band) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_req <= MODE_PWM;
        end else begin
            case (mode_req)
                MODE_PWM: if ({1'b0, power_q} > upper) mode_req <= MODE_PSH;
                MODE_PSH: if (power_q < lower)         mode_req <= MODE_PWM;
                default:  mode_req <= MODE_PWM;
            endcase
        end
    end

    // R7: entering phase-shift needs a load above the threshold
    assert_enter_above_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_req == MODE_PSH && $past(mode_req) == MODE_PWM) |-> ($past(power_q) > $past(thr_q)));

    // R7: leaving phase-shift needs a load below the threshold
    assert_leave_below_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_req == MODE_PWM && $past(mode_req) == MODE_PSH) |-> ($past(power_q) < $past(thr_q)));

endmodule

// File: rtl/dmg_frame.sv
module dmg_frame
    import dmg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cnt_t   period_len,
    input  cnt_t   duty_len,
    input  cnt_t   shift_len,
    input  cnt_t   dead_len,
    input  logic   dir_bwd,
    input  mode_e  mode_req,
    output cnt_t   cnt,
    output frame_t frame
);

    logic   wrap;
    frame_t next_frame;
    cnt_t   next_half;

    assign wrap = (frame.period == '0) || (cnt >= frame.period - cnt_t'(1));

    always_comb begin
        next_half         = period_len >> 1;
        next_frame.period = period_len;
        next_frame.half   = next_half;
        next_frame.on_end = (mode_req == MODE_PWM) ? cnt_min(duty_len, next_half) : next_half;
        next_frame.dead   = (dead_len == '0) ? cnt_t'(1) : dead_len;
        next_frame.shift  = (mode_req == MODE_PSH)
                          ? cnt_min(shift_len, next_half / cnt_t'(SHIFT_DIV)) : '0;
        next_frame.mode   = mode_req;
        next_frame.bwd    = dir_bwd;
    end

    // all settings are captured together, only when the carrier wraps
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            frame <= '0;
        end else if (wrap) begin
            cnt   <= '0;
            frame <= next_frame;
        end else begin
            cnt   <= cnt + cnt_t'(1);
        end
    end

    // R8: the active mode only moves on the first count of a period
    assert_mode_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(frame.mode) |-> (cnt == '0));

    // R1: the carrier never runs past the captured period
    assert_cnt_in_period_R1: assert property (@(posedge clk) disable iff (rst)
        (frame.period != '0) |-> (cnt < frame.period));

endmodule

// File: rtl/dmg_leg.sv
module dmg_leg
    import dmg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cnt_t   cnt,
    input  frame_t frame,
    input  cnt_t   delay,
    output logic   pair_a,
    output logic   pair_b
);

    cnt_t           phase;
    logic [CNT_W:0] b_start;
    logic [CNT_W:0] b_stop;
    logic           a_next;
    logic           b_next;

    always_comb begin
        phase   = wrap_sub(cnt, delay, frame.period);
        b_start = {1'b0, frame.half} + {1'b0, frame.dead};
        b_stop  = {1'b0, frame.half} + {1'b0, frame.on_end};
        a_next  = (phase >= frame.dead) && (phase < frame.on_end);
        b_next  = ({1'b0, phase} >= b_start) && ({1'b0, phase} < b_stop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_a <= 1'b0;
            pair_b <= 1'b0;
        end else begin
            pair_a <= a_next;
            pair_b <= b_next;
        end
    end

    // R2: the two diagonal pairs of a bridge never conduct together
    assert_pair_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(pair_a && pair_b));

    // R3: a pair may only turn on after the other has been off a cycle
    assert_dead_gap_b_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pair_b) |-> !$past(pair_a));

    assert_dead_gap_a_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pair_a) |-> !$past(pair_b));

endmodule

// File: rtl/dual_mode_gatedrv.sv
module dual_mode_gatedrv
    import dmg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_bwd,
    input  logic [CNT_W-1:0] period_len,
    input  logic [CNT_W-1:0] duty_len,
    input  logic [CNT_W-1:0] shift_len,
    input  logic [CNT_W-1:0] dead_len,
    input  logic [V_W-1:0]   v_hi,
    input  logic [I_W-1:0]   i_hi,
    input  logic [V_W-1:0]   v_lo,
    input  logic [I_W-1:0]   i_lo,
    input  logic [P_W-1:0]   thr_fwd,
    input  logic [P_W-1:0]   thr_bwd,
    input  logic [P_W-1:0]   hyst_band,
    output logic [7:0]       gate,
    output logic             mode_psh
);

    mode_e  mode_req;
    cnt_t   cnt;
    frame_t frame;
    cnt_t   delay   [NUM_BRIDGES];
    logic   pair_a  [NUM_BRIDGES];
    logic   pair_b  [NUM_BRIDGES];

    dmg_mode_sel u_sel (
        .clk       (clk),
        .rst       (rst),
        .dir_bwd   (dir_bwd),
        .v_hi      (v_hi),
        .i_hi      (i_hi),
        .v_lo      (v_lo),
        .i_lo      (i_lo),
        .thr_fwd   (thr_fwd),
        .thr_bwd   (thr_bwd),
        .hyst_band (hyst_band),
        .mode_req  (mode_req)
    );

    dmg_frame u_frame (
        .clk        (clk),
        .rst        (rst),
        .period_len (period_len),
        .duty_len   (duty_len),
        .shift_len  (shift_len),
        .dead_len   (dead_len),
        .dir_bwd    (dir_bwd),
        .mode_req   (mode_req),
        .cnt        (cnt),
        .frame      (frame)
    );

    // bridge 0 is the high side, bridge 1 the low side; the trailing
    // bridge is the one opposite to the power source
    generate
        for (genvar g = 0; g < NUM_BRIDGES; g++) begin : g_bridge
            if (g == 0) begin : g_hi
                assign delay[g] = frame.bwd ? frame.shift : '0;
            end else begin : g_lo
                assign delay[g] = frame.bwd ? '0 : frame.shift;
            end

            dmg_leg u_leg (
                .clk    (clk),
                .rst    (rst),
                .cnt    (cnt),
                .frame  (frame),
                .delay  (delay[g]),
                .pair_a (pair_a[g]),
                .pair_b (pair_b[g])
            );

            assign gate[4*g + 0] = pair_a[g];
            assign gate[4*g + 3] = pair_a[g];
            assign gate[4*g + 1] = pair_b[g];
            assign gate[4*g + 2] = pair_b[g];
        end
    endgenerate

    assign mode_psh = (frame.mode == MODE_PSH);

    // R4: in settled PWM mode both bridges switch in step
    assert_pwm_sync_R4: assert property (@(posedge clk) disable iff (rst)
        (!mode_psh && !$past(mode_psh)) |-> (gate[0] == gate[4] && gate[1] == gate[5]));

endmodule

// File: tb/dual_mode_gatedrv_bench.sv
module dual_mode_gatedrv_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dir_bwd = 1'b0;
    logic [11:0] period_len = 12'd100;
    logic [11:0] duty_len = 12'd40;
    logic [11:0] shift_len = 12'd8;
    logic [11:0] dead_len = 12'd3;
    logic [11:0] v_hi = '0, i_hi = '0, v_lo = '0, i_lo = '0;
    logic [23:0] thr_fwd = 24'd200;
    logic [23:0] thr_bwd = 24'd100;
    logic [23:0] hyst_band = 24'd20;
    logic [7:0]  gate;
    logic        mode_psh;

    int checks = 0;
    int errors = 0;
    int overlap_cnt = 0;

    always #5 clk = ~clk;

    dual_mode_gatedrv u_dual_mode_gatedrv (
        .clk(clk), .rst(rst), .dir_bwd(dir_bwd),
        .period_len(period_len), .duty_len(duty_len),
        .shift_len(shift_len), .dead_len(dead_len),
        .v_hi(v_hi), .i_hi(i_hi), .v_lo(v_lo), .i_lo(i_lo),
        .thr_fwd(thr_fwd), .thr_bwd(thr_bwd), .hyst_band(hyst_band),
        .gate(gate), .mode_psh(mode_psh)
    );

    typedef struct {
        string tag;
        int    mode;
        int    delta;
        int    width;
        int    gap;
        int    per;
    } exp_t;

    exp_t sb_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // ---------------- monitor ----------------
    int  mcyc = 0;
    bit  p1 = 0, p2 = 0, p5 = 0;
    bit  r1, f1, r2, r5;
    int  last5 = -100000;

    task automatic step();
        @(negedge clk);
        mcyc++;
        r1 = gate[0] && !p1;
        f1 = !gate[0] && p1;
        r2 = gate[1] && !p2;
        r5 = gate[4] && !p5;
        if (r5) last5 = mcyc;
        p1 = gate[0];
        p2 = gate[1];
        p5 = gate[4];
    endtask

    initial begin : monitor
        forever begin
            exp_t e;
            int t1, t5p, t1f, t2r, t1n, t5n, md, delta, lim;
            wait (sb_q.size() > 0);
            e = sb_q[0];
            do step(); while (!r1);
            do step(); while (!r1);
            t1 = mcyc; t5p = last5; md = mode_psh;
            t1f = -1; t2r = -1; t1n = -1; t5n = -1; lim = 0;
            while (!(t1n >= 0 && t5n >= 0) && lim < 4 * e.per) begin
                step();
                lim++;
                if (f1 && t1f < 0) t1f = mcyc;
                if (r2 && t1f >= 0 && t2r < 0) t2r = mcyc;
                if (r1 && t1n < 0) t1n = mcyc;
                if (r5 && t5n < 0) t5n = mcyc;
            end
            delta = (t5p >= t1 - e.per / 2) ? (t5p - t1) : (t5n - t1);
            chk(md == e.mode, {e.tag, " mode"}, md, e.mode);
            chk(delta == e.delta, {e.tag, " bridge delay"}, delta, e.delta);
            chk(t1f - t1 == e.width, {e.tag, " pair-A on-time"}, t1f - t1, e.width);
            chk(t2r - t1f == e.gap, {e.tag, " gap to pair B"}, t2r - t1f, e.gap);
            chk(t1n - t1 == e.per, {e.tag, " R1 period"}, t1n - t1, e.per);
            void'(sb_q.pop_front());
        end
    end

    // R2 pair integrity, watched every cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (gate[0] != gate[3] || gate[1] != gate[2] || gate[4] != gate[7] ||
                gate[5] != gate[6] || (gate[0] && gate[1]) || (gate[4] && gate[5]))
                overlap_cnt++;
        end
    end

    // R8 boundary timing: forward mode change -> gate[0] rise dead+1 later
    int  bcyc = 0;
    bit  pm = 0, pg0 = 0, armed = 0;
    int  tmode = 0, dexp = 0;
    always @(negedge clk) begin
        bcyc++;
        if (!rst) begin
            if (gate[0] && !pg0 && armed) begin
                chk((bcyc - tmode) == dexp, "R8 mode change on period boundary", bcyc - tmode, dexp);
                armed = 0;
            end
            if (mode_psh != pm && !dir_bwd) begin
                armed = 1;
                tmode = bcyc;
                dexp = int'(dead_len) + 1;
            end
        end
        pm = mode_psh;
        pg0 = gate[0];
    end

    // ---------------- driver ----------------
    task automatic run_case(input string tag, input int mode, input int delta,
                            input int width, input int gap);
        exp_t e;
        repeat (6 * int'(period_len)) @(posedge clk);
        e.tag = tag; e.mode = mode; e.delta = delta;
        e.width = width; e.gap = gap; e.per = int'(period_len);
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        finish_run();
    end

    initial begin : driver
        v_lo = 12'd50; i_lo = 12'd3;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(gate == 8'h00, "R9 gates low in reset", gate, 0);
        chk(mode_psh == 1'b0, "R9 mode PWM in reset", mode_psh, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(gate == 8'h00, "R9 gates low after reset", gate, 0);

        // forward light load, PWM
        run_case("R4 pwm forward", 0, 0, 37, 13);
        @(negedge clk) duty_len = 12'd70;
        run_case("R4 duty clamp", 0, 0, 47, 3);
        @(negedge clk) i_lo = 12'd6;                       // 300
        run_case("R5 R10 phase-shift forward", 1, 8, 47, 3);
        @(negedge clk) shift_len = 12'd30;
        run_case("R5 shift clamp", 1, 10, 47, 3);
        @(negedge clk) begin v_lo = 12'd38; i_lo = 12'd5; end // 190
        run_case("R7 hold inside band", 1, 10, 47, 3);
        @(negedge clk) begin v_lo = 12'd34; duty_len = 12'd40; end // 170
        run_case("R7 leave below band", 0, 0, 37, 13);
        @(negedge clk) v_lo = 12'd43;                      // 215
        run_case("R7 no entry inside band", 0, 0, 37, 13);
        // backward
        @(negedge clk) begin
            dir_bwd = 1'b1; v_hi = 12'd50; i_hi = 12'd3; v_lo = 12'd0; i_lo = 12'd0;
        end
        run_case("R6 R10 phase-shift backward", 1, -10, 47, 3);
        @(negedge clk) begin v_hi = 12'd20; v_lo = 12'd100; i_lo = 12'd10; end
        run_case("R6 backward uses high side", 0, 0, 37, 13);
        @(negedge clk) begin
            dir_bwd = 1'b0; v_lo = 12'd30; i_lo = 12'd5; v_hi = 12'd100; i_hi = 12'd10;
        end
        run_case("R6 forward uses low side", 0, 0, 37, 13);
        @(negedge clk) dead_len = 12'd6;
        run_case("R3 dead time", 0, 0, 34, 16);
        @(negedge clk) period_len = 12'd80;
        run_case("R1 new period", 0, 0, 34, 6);

        chk(overlap_cnt == 0, "R2 pair integrity", overlap_cnt, 0);
        finish_run();
    end

endmodule